// File: doc/BRIEF.md
# Write Unlock Command Sequencer

This block sits behind the bus front end of a byte-wide non-volatile memory and watches every decoded write cycle (a 15-bit address and an 8-bit data byte, presented as a one-cycle strobe). Nothing may reach the array until three command writes arrive in the right order. The first is byte 0xAA at address 0x5555, the second is 0x55 at 0x2AAA, and the third is 0xA0 at 0x5555. Each of these writes must arrive within a bounded time of the one before it. Any write that breaks the order or arrives late is dropped without notice, and the sequencer falls back to its locked state.

Each write receives exactly one registered verdict one clock after its strobe. The verdict is one of three: the write may be stored, the write is a command byte that must never be stored, or the write is blocked. Once the sequence is complete, a page-load window opens. Data writes to a single page are then passed, and each accepted write restarts the timer. When the timer lapses after at least one data byte, a one-cycle close pulse tells the downstream programming logic to start its cycle. The window limit is a clock count parameter. An external timeout pulse can also end the window, so a shared system timer may be used in place of the internal counter.

Top module: `unlock_seq`

## Requirements
- R1: After reset, all verdict outputs, `win_kick`, `page_open` and `page_close` are low.
- R2: The three writes 0xAA@0x5555, 0x55@0x2AAA and 0xA0@0x5555, given in that order, each get `dec_cmd`=1 and `dec_pass`=0. `page_open` is 1 in the cycle the third verdict appears.
- R3: While locked, a write that is not the first command step gets `dec_block`=1, and `page_open` stays 0.
- R4: A write whose address or data does not match the expected step after the first or second step gets `dec_block`=1 and relocks the sequencer. A correct later step is then blocked too.
- R5: The next write in the sequence is accepted if it arrives no more than WIN_CYCLES clocks after the previous accepted write. If it arrives WIN_CYCLES+1 clocks or later after the previous accepted write, the window has lapsed, and the write is judged as if the sequencer were locked.
- R6: While the window is open, data writes get `dec_pass`=1 and `dec_cmd`=0.
- R7: The first data write fixes the page, which is address bits 14 down to 7. A later write to another page gets `dec_block`=1, does not restart the timer, and leaves `page_open` at 1.
- R8: When the window lapses after at least one passed data write, `page_close` pulses for one cycle. The pulse appears WIN_CYCLES+1 clocks after the last accepted write, in the same cycle that `page_open` falls. If no data write was passed, `page_open` falls with no pulse.
- R9: Every write strobe produces exactly one of `dec_pass`, `dec_cmd` and `dec_block` in the next cycle. None of them is high in any other cycle.
- R10: `win_kick` pulses alongside every `dec_pass` or `dec_cmd` verdict and never alongside `dec_block`.
- R11: While the sequencer is not locked, an `ext_tick` pulse ends the window in the same way an internal timer lapse does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | One-cycle strobe per decoded write |
| wr_addr | input | 15 | Write address |
| wr_data | input | 8 | Write data |
| ext_tick | input | 1 | External window timeout pulse |
| dec_pass | output | 1 | Write may be stored |
| dec_cmd | output | 1 | Write is a command byte, not to be stored |
| dec_block | output | 1 | Write discarded |
| win_kick | output | 1 | Timer restart, one pulse per accepted write |
| page_open | output | 1 | Page-load window is open |
| page_close | output | 1 | Window ended after data was loaded |

## Verification
The hardest case to reach from the ports is a write that lands in the very clock in which the window lapses. In that clock the timeout must take precedence, and the write must be judged from the locked state. The bench reaches this case by placing a counted number of idle clocks between two prefix writes: first WIN_CYCLES-1 idle clocks, where the write must still be accepted, then WIN_CYCLES idle clocks, where it must be rejected. It uses the same counted gap after a data write to pin the close pulse to an exact cycle.

// File: rtl/unlock_seq_pkg.sv
package unlock_seq_pkg;

  typedef enum logic [2:0] {
    ST_LOCKED = 3'd0,
    ST_ARM1   = 3'd1,
    ST_ARM2   = 3'd2,
    ST_OPEN   = 3'd3,
    ST_LOAD   = 3'd4
  } useq_state_e;

  localparam int unsigned STEPS = 3;

endpackage

// File: rtl/unlock_seq_match.sv
module unlock_seq_match #(
  parameter int unsigned    ADDR_W  = 15,
  parameter int unsigned    DATA_W  = 8,
  parameter logic [14:0]    KEY_A0  = 15'h5555,
  parameter logic [14:0]    KEY_A1  = 15'h2AAA,
  parameter logic [7:0]     KEY_D0  = 8'hAA,
  parameter logic [7:0]     KEY_D1  = 8'h55,
  parameter logic [7:0]     KEY_D2  = 8'hA0
) (
  input  logic [1:0]        step_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              hit_o
);
  import unlock_seq_pkg::*;

  logic [STEPS-1:0] step_hit;

  for (genvar s = 0; s < STEPS; s++) begin : g_step
    localparam logic [ADDR_W-1:0] EXP_A = (s == 1) ? ADDR_W'(KEY_A1) : ADDR_W'(KEY_A0);
    localparam logic [DATA_W-1:0] EXP_D = (s == 0) ? DATA_W'(KEY_D0) :
                                          (s == 1) ? DATA_W'(KEY_D1) : DATA_W'(KEY_D2);
    assign step_hit[s] = (addr_i == EXP_A) && (data_i == EXP_D);
  end

  always_comb begin
    hit_o = 1'b0;
    if (32'(step_i) < STEPS) hit_o = step_hit[step_i];
  end

endmodule

// File: rtl/unlock_seq_window.sv
module unlock_seq_window #(
  parameter int unsigned WIN_CYCLES = 20000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic kick_i,
  input  logic ext_tick_i,
  output logic expire_o
);
  localparam int unsigned CNT_W = $clog2(WIN_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(WIN_CYCLES);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = kick_i || !active_i || (cnt_q != CNT_LIM);

  always_comb begin
    cnt_d = cnt_q;
    if (kick_i || !active_i) cnt_d = '0;
    else if (cnt_q != CNT_LIM) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expire_o = active_i && ((cnt_q == CNT_LIM) || ext_tick_i);

  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LIM);

  a_r5_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !active_i |=> (cnt_q == '0));

endmodule

// File: rtl/unlock_seq_ctrl.sv
module unlock_seq_ctrl #(
  parameter int unsigned ADDR_W   = 15,
  parameter int unsigned PAGE_LSB = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic              step_hit_i,
  input  logic              expire_i,
  output logic [1:0]        step_o,
  output logic              active_o,
  output logic              kick_o,
  output logic              dec_pass_o,
  output logic              dec_cmd_o,
  output logic              dec_block_o,
  output logic              win_kick_o,
  output logic              page_open_o,
  output logic              page_close_o
);
  import unlock_seq_pkg::*;

  localparam int unsigned PG_W = ADDR_W - PAGE_LSB;

  useq_state_e state_q, state_d, eff_state;
  logic [PG_W-1:0] page_q, page_d;
  logic            page_en;
  logic            pass_d, cmd_d, block_d, close_d;
  logic            pass_q, cmd_q, block_q, kick_q, close_q;
  logic [PG_W-1:0] wr_page;

  assign wr_page   = wr_addr_i[ADDR_W-1:PAGE_LSB];
  assign eff_state = expire_i ? ST_LOCKED : state_q;
  assign step_o    = eff_state[1:0];
  assign active_o  = (state_q != ST_LOCKED);

  always_comb begin
    state_d = eff_state;
    page_d  = page_q;
    page_en = 1'b0;
    pass_d  = 1'b0;
    cmd_d   = 1'b0;
    block_d = 1'b0;
    close_d = expire_i && (state_q == ST_LOAD);
    if (wr_valid_i) begin
      unique case (eff_state)
        ST_LOCKED: begin
          if (step_hit_i) begin cmd_d = 1'b1; state_d = ST_ARM1; end
          else            begin block_d = 1'b1; state_d = ST_LOCKED; end
        end
        ST_ARM1: begin
          if (step_hit_i) begin cmd_d = 1'b1; state_d = ST_ARM2; end
          else            begin block_d = 1'b1; state_d = ST_LOCKED; end
        end
        ST_ARM2: begin
          if (step_hit_i) begin cmd_d = 1'b1; state_d = ST_OPEN; end
          else            begin block_d = 1'b1; state_d = ST_LOCKED; end
        end
        ST_OPEN: begin
          pass_d  = 1'b1;
          page_d  = wr_page;
          page_en = 1'b1;
          state_d = ST_LOAD;
        end
        ST_LOAD: begin
          if (wr_page == page_q) pass_d  = 1'b1;
          else                   block_d = 1'b1;
        end
        default: begin
          block_d = 1'b1;
          state_d = ST_LOCKED;
        end
      endcase
    end
  end

  assign kick_o = pass_d || cmd_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_LOCKED;
      pass_q  <= 1'b0;
      cmd_q   <= 1'b0;
      block_q <= 1'b0;
      kick_q  <= 1'b0;
      close_q <= 1'b0;
    end else begin
      state_q <= state_d;
      pass_q  <= pass_d;
      cmd_q   <= cmd_d;
      block_q <= block_d;
      kick_q  <= kick_o;
      close_q <= close_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       page_q <= '0;
    else if (page_en) page_q <= page_d;
  end

  assign dec_pass_o   = pass_q;
  assign dec_cmd_o    = cmd_q;
  assign dec_block_o  = block_q;
  assign win_kick_o   = kick_q;
  assign page_open_o  = (state_q == ST_OPEN) || (state_q == ST_LOAD);
  assign page_close_o = close_q;

  // R9: one verdict per strobe, none otherwise
  a_r9_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_i |=> ($countones({dec_pass_o, dec_cmd_o, dec_block_o}) == 1));
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid_i |=> !(dec_pass_o || dec_cmd_o || dec_block_o));
  // R2: window opens only on a command verdict
  a_r2_open_on_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(page_open_o) |-> dec_cmd_o);
  // R6: passed writes only inside an open window
  a_r6_pass_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    dec_pass_o |-> page_open_o);
  // R8: close pulse coincides with window falling
  a_r8_close_drops: assert property (@(posedge clk) disable iff (!rst_n)
    page_close_o |-> (!page_open_o && $past(page_open_o)));
  // R5: lapse without a new write relocks
  a_r5_timeout_locks: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_i && !wr_valid_i) |=> !page_open_o);
  // R10: timer restart never accompanies a block
  a_r10_kick_no_block: assert property (@(posedge clk) disable iff (!rst_n)
    !(win_kick_o && dec_block_o));

endmodule

// File: rtl/unlock_seq.sv
module unlock_seq #(
  parameter int unsigned ADDR_W     = 15,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned PAGE_LSB   = 7,
  parameter int unsigned WIN_CYCLES = 20000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ext_tick,
  output logic              dec_pass,
  output logic              dec_cmd,
  output logic              dec_block,
  output logic              win_kick,
  output logic              page_open,
  output logic              page_close
);
  logic [1:0] step;
  logic       step_hit;
  logic       active;
  logic       kick;
  logic       expire;

  unlock_seq_match #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_match (
    .step_i (step),
    .addr_i (wr_addr),
    .data_i (wr_data),
    .hit_o  (step_hit)
  );

  unlock_seq_window #(
    .WIN_CYCLES (WIN_CYCLES)
  ) u_window (
    .clk        (clk),
    .rst_n      (rst_n),
    .active_i   (active),
    .kick_i     (kick),
    .ext_tick_i (ext_tick),
    .expire_o   (expire)
  );

  unlock_seq_ctrl #(
    .ADDR_W   (ADDR_W),
    .PAGE_LSB (PAGE_LSB)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_valid_i   (wr_valid),
    .wr_addr_i    (wr_addr),
    .step_hit_i   (step_hit),
    .expire_i     (expire),
    .step_o       (step),
    .active_o     (active),
    .kick_o       (kick),
    .dec_pass_o   (dec_pass),
    .dec_cmd_o    (dec_cmd),
    .dec_block_o  (dec_block),
    .win_kick_o   (win_kick),
    .page_open_o  (page_open),
    .page_close_o (page_close)
  );

endmodule

// File: tb/unlock_seq_bench.sv
`timescale 1ns/1ps
module unlock_seq_bench;
  localparam int WIN = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_valid;
  logic [14:0] wr_addr;
  logic [7:0]  wr_data;
  logic        ext_tick;
  logic        dec_pass, dec_cmd, dec_block, win_kick, page_open, page_close;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #2.5 clk = ~clk;

  unlock_seq #(.WIN_CYCLES(WIN)) u_unlock_seq (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .ext_tick(ext_tick), .dec_pass(dec_pass),
    .dec_cmd(dec_cmd), .dec_block(dec_block), .win_kick(win_kick),
    .page_open(page_open), .page_close(page_close)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // verdict code {pass,cmd,block,kick}
  task automatic wr(input logic [14:0] a, input logic [7:0] d, output logic [3:0] v);
    wr_addr  = a;
    wr_data  = d;
    wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
    v = {dec_pass, dec_cmd, dec_block, win_kick};
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic unlock(input string req);
    logic [3:0] v;
    wr(15'h5555, 8'hAA, v); check({req, " step1 cmd"}, v, 4'b0101);
    wr(15'h2AAA, 8'h55, v); check({req, " step2 cmd"}, v, 4'b0101);
    wr(15'h5555, 8'hA0, v); check({req, " step3 cmd"}, v, 4'b0101);
    check({req, " open after prefix"}, page_open, 1);
  endtask

  task automatic drain();
    idle(WIN + 3);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; wr_valid = 1'b0; wr_addr = '0; wr_data = '0; ext_tick = 1'b0;
    idle(3);
    check("R1 outputs low in reset",
          {dec_pass, dec_cmd, dec_block, win_kick, page_open, page_close}, 0);
    rst_n = 1'b1;
    idle(2);
    check("R1 outputs low after reset",
          {dec_pass, dec_cmd, dec_block, win_kick, page_open, page_close}, 0);
  endtask

  task automatic t_no_prefix();
    logic [3:0] v;
    wr(15'h1234, 8'h77, v); check("R3 plain write blocked", v, 4'b0010);
    wr(15'h2AAA, 8'hAA, v); check("R3 key data wrong addr blocked", v, 4'b0010);
    wr(15'h5555, 8'hA0, v); check("R3 third key alone blocked", v, 4'b0010);
    check("R3 window stays shut", page_open, 0);
    idle(1);
    check("R9 no verdict without strobe", {dec_pass, dec_cmd, dec_block, win_kick}, 0);
  endtask

  task automatic t_bad_step();
    logic [3:0] v;
    wr(15'h5555, 8'hAA, v); check("R4 first step", v, 4'b0101);
    wr(15'h2AAA, 8'h56, v); check("R4 wrong data blocked", v, 4'b0010);
    wr(15'h5555, 8'hA0, v); check("R4 relocked, late step blocked", v, 4'b0010);
    check("R4 window shut", page_open, 0);
    wr(15'h5555, 8'hAA, v); check("R4 restart step1", v, 4'b0101);
    wr(15'h2AAA, 8'h55, v); check("R4 step2", v, 4'b0101);
    wr(15'h5554, 8'hA0, v); check("R4 wrong addr step3 blocked", v, 4'b0010);
    check("R4 still shut", page_open, 0);
  endtask

  task automatic t_unlock_write();
    logic [3:0] v;
    unlock("R2");
    wr(15'h1200, 8'h11, v); check("R6 first data passes", v, 4'b1001);
    wr(15'h1205, 8'h22, v); check("R6 same page passes", v, 4'b1001);
    wr(15'h5555, 8'hAA, v); check("R7 other page blocked", v, 4'b0010);
    check("R7 window still open", page_open, 1);
    wr(15'h127F, 8'h33, v); check("R10 last data kick", v, 4'b1001);
    idle(WIN);
    check("R8 no close before limit", {page_close, page_open}, 2'b01);
    idle(1);
    check("R8 close at limit", {page_close, page_open}, 2'b10);
    idle(1);
    check("R8 close is one pulse", page_close, 0);
  endtask

  task automatic t_gap();
    logic [3:0] v;
    wr(15'h5555, 8'hAA, v); check("R5 step1", v, 4'b0101);
    idle(WIN - 1);
    wr(15'h2AAA, 8'h55, v); check("R5 step2 at limit accepted", v, 4'b0101);
    idle(WIN);
    wr(15'h5555, 8'hA0, v); check("R5 late step3 blocked", v, 4'b0010);
    check("R5 window shut after late", page_open, 0);
  endtask

  task automatic t_open_lapse();
    unlock("R8");
    idle(WIN);
    check("R8 open until limit", page_open, 1);
    idle(1);
    check("R8 empty window lapses without close", {page_close, page_open}, 2'b00);
  endtask

  task automatic t_ext_tick();
    logic [3:0] v;
    unlock("R11");
    wr(15'h0080, 8'h5A, v); check("R11 data passes", v, 4'b1001);
    idle(2);
    ext_tick = 1'b1;
    @(negedge clk);
    ext_tick = 1'b0;
    check("R11 external tick closes window", {page_close, page_open}, 2'b10);
    ext_tick = 1'b1;
    @(negedge clk);
    ext_tick = 1'b0;
    check("R11 tick while locked ignored", {page_close, page_open}, 2'b00);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    @(negedge clk);
    t_no_prefix();
    t_bad_step();
    t_unlock_write();
    drain();
    t_gap();
    drain();
    t_open_lapse();
    drain();
    t_ext_tick();
    drain();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule